// File: doc/BRIEF.md
# Synchronous Parity Frame Receiver with Break

This block listens to a two-wire synchronous serial link: a link clock driven by the far end and a shared data line. It never drives the data line. Both inputs are brought into the system clock domain through a synchroniser and an edge detector. The data line is captured on each rising link-clock edge. Each falling edge closes a bit slot, and that slot's captured value is processed at that edge.

Bit slots are assembled into 11-bit frames. Each byte that passes both its parity check and its stop-bit check is delivered with a single-cycle strobe. Bad parity and a low stop bit are each reported on their own strobe.

Independently of frame alignment, the block counts consecutive low slots. A run of eleven or more low slots is a break. The break is reported on the first high slot that follows it. That report also throws away any partly assembled frame.

Top module: `sfr_rx`

## Requirements
- R1: The data line is captured on link-clock rising edges, and a bit slot is processed only at a link-clock falling edge. The first falling edge after reset does not produce a slot.
- R2: A frame is a low start bit, then eight data bits with the least significant first, then a parity bit, then a stop bit. A good frame raises `byte_valid` with the byte on `byte_data`.
- R3: Parity is even over the eight data bits together with the parity bit. On a mismatch, `parity_err` pulses and `byte_valid` stays low.
- R4: A low stop bit pulses `frame_err` and suppresses `byte_valid`.
- R5: High slots seen while waiting for a start bit are ignored. This means a second high stop bit, or any idle gap between frames, has no effect on the next frame.
- R6: Eleven consecutive low slots, at any alignment to the frames, make a break pending. `brk` does not pulse while the line stays low, however long the break lasts. It pulses exactly once on the first high slot after the break.
- R7: When the break is reported, any partial frame is discarded and the high slot that ends the break is not taken as a start bit. The next frame is decoded from its own start bit.
- R8: Each of `byte_valid`, `parity_err`, `frame_err` and `brk` is at most one system-clock cycle wide per event.
- R9: While `rst_n` is low on a clock edge, all strobes are cleared, together with the zero counter, the partial frame and the bit-slot tracking.
- R10: A run of ten low slots followed by a high slot is not a break. For example, byte 0x00 with parity 0 and a high stop bit is accepted as a normal byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_clk | input | 1 | Link clock, asynchronous to `clk` |
| link_dat | input | 1 | Observed data line, asynchronous to `clk` |
| byte_valid | output | 1 | One-cycle strobe for a good frame |
| byte_data | output | 8 | Byte of the last good frame |
| parity_err | output | 1 | One-cycle strobe for a parity mismatch |
| frame_err | output | 1 | One-cycle strobe for a low stop bit |
| brk | output | 1 | One-cycle strobe at the end of a break |

## Verification
The hardest case to reach from the ports is a break that starts partway through a frame. In that case the zero run first completes the current frame with a low stop bit. It then leaves a new partial frame behind, which must be dropped when the break ends. The stimulus reaches this case by sending a frame whose upper data bits, parity bit and stop bit are all low, and then holding the line low for several more slots. The bench expects one frame error, then one break, and then correct decoding of a following frame, which only happens if the leftover partial frame was discarded. The bench also sends ten zeros with a good stop bit, which sits just short of a break, and it checks that the first falling edge after reset is ignored.

// File: rtl/sfr_pkg.sv
// Package: shared frame geometry for the synchronous frame receiver.
// Assumes one start bit, one parity bit and one stop bit around the data.
package sfr_pkg;
    localparam int unsigned DATA_BITS  = 8;
    localparam int unsigned FRAME_BITS = DATA_BITS + 3;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
endpackage

// File: rtl/sfr_sync_edge.sv
// Module: brings the link clock and data into the system clock domain and
// reports link-clock edges. Assumes both inputs are asynchronous to clk and
// that each link-clock level lasts several clk cycles.
module sfr_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lclk_in,
    input  logic ldat_in,
    output logic lclk_rise,
    output logic lclk_fall,
    output logic ldat_sync
);
    logic [STAGES-1:0] clk_ff;
    logic [STAGES-1:0] dat_ff;
    logic              clk_prev;

    // Synchroniser chains and previous-level register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_ff   <= '0;
            dat_ff   <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_ff   <= {clk_ff[STAGES-2:0], lclk_in};
            dat_ff   <= {dat_ff[STAGES-2:0], ldat_in};
            clk_prev <= clk_ff[STAGES-1];
        end
    end

    // Edge decode on the synchronised link clock.
    always_comb begin
        lclk_rise = clk_ff[STAGES-1] & ~clk_prev;
        lclk_fall = ~clk_ff[STAGES-1] & clk_prev;
        ldat_sync = dat_ff[STAGES-1];
    end
endmodule

// File: rtl/sfr_bit_slot.sv
// Module: turns link-clock edges into bit slots. Captures data on rising
// edges and issues one slot per falling edge, skipping the first falling
// edge after reset since no complete slot precedes it.
module sfr_bit_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic dat,
    output logic slot_valid,
    output logic slot_bit
);
    logic sample;
    logic seen_fall;

    // Capture on rise, emit the captured slot on every fall but the first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample     <= 1'b0;
            seen_fall  <= 1'b0;
            slot_valid <= 1'b0;
            slot_bit   <= 1'b0;
        end else begin
            slot_valid <= 1'b0;
            if (rise) begin
                sample <= dat;
            end
            if (fall) begin
                seen_fall  <= 1'b1;
                slot_valid <= seen_fall;
                slot_bit   <= sample;
            end
        end
    end

    AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |=> !slot_valid); // R8
    AST_FIRST_FALL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> $past(seen_fall)); // R1
endmodule

// File: rtl/sfr_frame_asm.sv
// Module: assembles bit slots into parity-checked frames and detects breaks
// as runs of low slots at any alignment. Assumes slots arrive as single-cycle
// strobes; all outputs are registered single-cycle strobes.
module sfr_frame_asm
    import sfr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_valid,
    input  logic                 slot_bit,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 brk
);
    localparam int unsigned SH_W = FRAME_BITS - 1;

    logic [CNT_W-1:0] zero_cnt;
    logic [CNT_W-1:0] bit_cnt;
    logic [SH_W-1:0]  shreg;
    logic             brk_pend;
    logic             zero_hit;
    logic             par_ok;

    // Break threshold reached on this slot, and parity of the finished frame.
    always_comb begin
        zero_hit = slot_valid && !slot_bit && (zero_cnt == CNT_W'(FRAME_BITS - 1));
        par_ok   = ~(^shreg[SH_W-1:1]);
    end

    // Saturating count of consecutive low slots, independent of frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_cnt <= '0;
        end else if (slot_valid) begin
            if (slot_bit) begin
                zero_cnt <= '0;
            end else if (zero_cnt != CNT_W'(FRAME_BITS)) begin
                zero_cnt <= zero_cnt + 1'b1;
            end
        end
    end

    // Frame collection, break handling and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            brk_pend   <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            brk        <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            brk        <= 1'b0;
            if (slot_valid) begin
                if (brk_pend) begin
                    if (slot_bit) begin
                        brk      <= 1'b1;
                        brk_pend <= 1'b0;
                        bit_cnt  <= '0;
                    end
                end else if (zero_hit) begin
                    brk_pend <= 1'b1;
                end else if (bit_cnt == '0 && slot_bit) begin
                    bit_cnt <= '0;
                end else if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                    bit_cnt    <= '0;
                    byte_valid <= par_ok && slot_bit;
                    parity_err <= !par_ok;
                    frame_err  <= !slot_bit;
                    if (par_ok && slot_bit) begin
                        byte_data <= shreg[DATA_BITS:1];
                    end
                end else begin
                    shreg   <= {slot_bit, shreg[SH_W-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    AST_BRK_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> $past(brk_pend)); // R6
    AST_ZERO_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cnt <= CNT_W'(FRAME_BITS)); // R6
    AST_HOLD_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pend && $past(brk_pend)) |-> $stable(bit_cnt)); // R7
    AST_BRK_DROPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> (bit_cnt == '0)); // R7
    AST_OUT_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid || parity_err || frame_err || brk) |-> $past(slot_valid)); // R1
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R8
endmodule

// File: rtl/sfr_rx.sv
// Module: top of the passive synchronous frame receiver. Observes the link
// clock and data line only; never drives either. Assumes link-clock phases
// span at least several system-clock cycles.
module sfr_rx
    import sfr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_clk,
    input  logic                 link_dat,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 brk
);
    logic rise_w;
    logic fall_w;
    logic dat_w;
    logic slot_v;
    logic slot_b;

    sfr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .lclk_in   (link_clk),
        .ldat_in   (link_dat),
        .lclk_rise (rise_w),
        .lclk_fall (fall_w),
        .ldat_sync (dat_w)
    );

    sfr_bit_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise_w),
        .fall       (fall_w),
        .dat        (dat_w),
        .slot_valid (slot_v),
        .slot_bit   (slot_b)
    );

    sfr_frame_asm u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_valid (slot_v),
        .slot_bit   (slot_b),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .parity_err (parity_err),
        .frame_err  (frame_err),
        .brk        (brk)
    );
endmodule

// File: tb/sfr_rx_bench.sv
module sfr_rx_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_clk = 1'b0;
    logic       link_dat = 1'b1;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       parity_err;
    logic       frame_err;
    logic       brk;

    int n_checks = 0;
    int n_errors = 0;
    int n_byte = 0, n_perr = 0, n_ferr = 0, n_brk = 0, n_wide = 0;
    logic [7:0] last_data = 8'h00;
    logic prev_bv = 1'b0, prev_pe = 1'b0, prev_fe = 1'b0, prev_bk = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfr_rx u_sfr_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_clk   (link_clk),
        .link_dat   (link_dat),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .parity_err (parity_err),
        .frame_err  (frame_err),
        .brk        (brk)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin n_byte++; last_data = byte_data; end
            if (parity_err) n_perr++;
            if (frame_err)  n_ferr++;
            if (brk)        n_brk++;
            if ((byte_valid && prev_bv) || (parity_err && prev_pe) ||
                (frame_err && prev_fe) || (brk && prev_bk)) n_wide++;
        end
        prev_bv = byte_valid; prev_pe = parity_err;
        prev_fe = frame_err;  prev_bk = brk;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_byte = 0; n_perr = 0; n_ferr = 0; n_brk = 0;
    endtask

    task automatic send_bit(input logic b);
        link_dat = b;
        repeat (2) @(negedge clk);
        link_clk = 1'b1;
        repeat (4) @(negedge clk);
        link_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic p, input logic s);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(p);
        send_bit(s);
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        link_clk = 1'b0;
        link_dat = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        do_reset();
        // R9: reset state
        check("R9 byte_valid after reset", int'(byte_valid), 0);
        check("R9 strobes after reset", int'(parity_err | frame_err | brk), 0);

        // R1: first falling edge after reset is ignored (captured 0 must not start a frame)
        clear_mon();
        send_bit(1'b0);
        send_frame(8'hA5, even_par(8'hA5), 1'b1);
        settle();
        check("R1 byte count after first-fall skip", n_byte, 1);
        check("R1 byte value after first-fall skip", int'(last_data), 8'hA5);

        // R2: directed LSB-first byte
        clear_mon();
        send_bit(1'b1);
        send_frame(8'h01, even_par(8'h01), 1'b1);
        settle();
        check("R2 byte count", n_byte, 1);
        check("R2 LSB-first value", int'(last_data), 8'h01);

        // R3: parity error
        clear_mon();
        send_frame(8'h3C, ~even_par(8'h3C), 1'b1);
        settle();
        check("R3 parity_err count", n_perr, 1);
        check("R3 no byte on parity error", n_byte, 0);

        // R4: low stop bit
        clear_mon();
        send_frame(8'h81, even_par(8'h81), 1'b0);
        send_bit(1'b1);
        settle();
        check("R4 frame_err count", n_ferr, 1);
        check("R4 no byte on frame error", n_byte, 0);
        check("R4 no break", n_brk, 0);

        // R5: idle highs and a second stop bit between back-to-back frames
        clear_mon();
        repeat (3) send_bit(1'b1);
        send_frame(8'h5A, even_par(8'h5A), 1'b1);
        send_bit(1'b1);
        send_frame(8'hC3, even_par(8'hC3), 1'b1);
        settle();
        check("R5 two bytes with two stop bits", n_byte, 2);
        check("R5 second byte value", int'(last_data), 8'hC3);
        check("R5 no errors", n_perr + n_ferr, 0);

        // R10: ten zeros then high is a normal byte, not a break
        clear_mon();
        send_frame(8'h00, 1'b0, 1'b1);
        settle();
        check("R10 byte 0x00 accepted", n_byte, 1);
        check("R10 value 0x00", int'(last_data), 0);
        check("R10 no break", n_brk, 0);

        // R6: aligned break of exactly 11 zeros
        clear_mon();
        repeat (11) send_bit(1'b0);
        settle();
        check("R6 no brk while line low", n_brk, 0);
        send_bit(1'b1);
        settle();
        check("R6 brk on first high", n_brk, 1);
        check("R6 no frame output for aligned break", n_byte + n_ferr + n_perr, 0);

        // R6: long break yields one strobe
        clear_mon();
        repeat (25) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        settle();
        check("R6 long break single brk", n_brk, 1);

        // R7: unaligned break: data 0x0F, low parity/stop, then more zeros
        clear_mon();
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(i < 4);
        send_bit(1'b0);
        send_bit(1'b0);
        repeat (5) send_bit(1'b0);
        send_bit(1'b1);
        settle();
        check("R7 frame_err before unaligned break", n_ferr, 1);
        check("R6 brk at unaligned break", n_brk, 1);
        clear_mon();
        send_frame(8'h96, even_par(8'h96), 1'b1);
        settle();
        check("R7 frame after break decoded", n_byte, 1);
        check("R7 value after break", int'(last_data), 8'h96);

        // R9: reset mid-frame drops the partial frame
        clear_mon();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        do_reset();
        send_bit(1'b1);
        send_frame(8'h42, even_par(8'h42), 1'b1);
        settle();
        check("R9 byte after mid-frame reset", n_byte, 1);
        check("R9 value after mid-frame reset", int'(last_data), 8'h42);

        // Random frames: R2, R3, R4
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            logic p, s;
            int gaps;
            d = 8'($urandom);
            p = even_par(d) ^ (($urandom % 4) == 0);
            s = ($urandom % 5) != 0;
            if (d == 8'h00 && p == 1'b0) s = 1'b1;
            gaps = 1 + ($urandom % 3);
            clear_mon();
            send_frame(d, p, s);
            repeat (gaps) send_bit(1'b1);
            settle();
            check("R2 random byte count", n_byte, int'((p == even_par(d)) && s));
            if ((p == even_par(d)) && s)
                check("R2 random byte value", int'(last_data), int'(d));
            check("R3 random parity_err", n_perr, int'(p != even_par(d)));
            check("R4 random frame_err", n_ferr, int'(!s));
        end

        // R8: no strobe was ever wider than one cycle
        check("R8 strobe width", n_wide, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule